// File: doc/BRIEF.md
# Scrolling Display Row Address Generator

This block feeds the display scan with the memory row to fetch for each common line of a dot-matrix panel. A start-line register, written by a single command, chooses which memory row lands on common line 0. Changing that register scrolls the picture or flips between pages, and the display memory itself is left untouched.

A frame-start pulse copies the start-line register into a modulo-64 row counter and clears the common-line index. Each line-clock pulse then moves both forward by one step. Common lines 0 to 63 show the scrolled rows, wrapping from 63 back to 0. Common line 64 always shows memory row 64, the icon row, and the start line has no effect on it. A start-line write never disturbs the frame in progress. It takes effect at the next frame start.

Top module: `disp_row_addr_gen`

## Requirements
- R1: While rst_ni is low, and after its release until the first pulse, row_addr_o and com_idx_o are 0. The start-line register resets to 0.
- R2: The start-line register changes only on a clock edge with start_wr_i high, and it then takes start_val_i. A write made in the middle of a frame leaves the rest of that frame's addresses unchanged.
- R3: One cycle after a frame_start_i pulse, com_idx_o is 0 and row_addr_o equals the start-line register as it stood before that edge. A write in the same cycle as frame_start_i applies only from the following frame.
- R4: Each line_clk_i pulse while com_idx_o < 64 increments com_idx_o. For com_idx_o = k in 0..63, row_addr_o = (start + k) mod 64.
- R5: When com_idx_o is 64 (the icon line), row_addr_o is 64, whatever the start line is.
- R6: Once com_idx_o is 64, further line_clk_i pulses leave both outputs unchanged until the next frame_start_i.
- R7: When frame_start_i and line_clk_i are high in the same cycle, frame_start_i wins and the line pulse is dropped.
- R8: In a cycle with neither frame_start_i nor line_clk_i, both outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_wr_i | input | 1 | Start-line command strobe |
| start_val_i | input | 6 | Start-line value written by the command |
| frame_start_i | input | 1 | Frame-start pulse, one cycle |
| line_clk_i | input | 1 | Line-advance pulse, one cycle |
| row_addr_o | output | 7 | Memory row address for the current common line |
| com_idx_o | output | 7 | Current common-line index, 0 to 64 |

## Verification
Every output comes from a register, so each result is due exactly one clock edge after the pulse or write that causes it. The bench drives inputs on the falling edge, lets one rising edge pass, and compares both outputs on the next falling edge against a model of the form (start + k) mod 64, with row 64 used for line 64. Start-line writes are checked through their delayed effect. Row addresses are compared both before and after the next frame start, which shows that a write only becomes visible at that boundary.

// File: rtl/disp_scan_pkg.sv
package disp_scan_pkg;
  typedef enum logic {
    PH_SCAN = 1'b0,
    PH_ICON = 1'b1
  } scan_phase_e;
endpackage

// File: rtl/dsa_start_reg.sv
module dsa_start_reg #(
  parameter int LINE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [LINE_W-1:0] val_i,
  output logic [LINE_W-1:0] start_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   start_o <= '0;
    else if (wr_i) start_o <= val_i;
  end
endmodule

// File: rtl/dsa_line_seq.sv
module dsa_line_seq
  import disp_scan_pkg::*;
#(
  parameter int LINE_W = 6,
  localparam int COM_W = LINE_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              line_clk_i,
  input  logic [LINE_W-1:0] start_i,
  output logic [LINE_W-1:0] row_cnt_o,
  output logic [COM_W-1:0]  com_o,
  output scan_phase_e       phase_o
);
  localparam logic [COM_W-1:0] LAST_SCAN = COM_W'((1 << LINE_W) - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_cnt_o <= '0;
      com_o     <= '0;
      phase_o   <= PH_SCAN;
    end else if (frame_start_i) begin
      row_cnt_o <= start_i;
      com_o     <= '0;
      phase_o   <= PH_SCAN;
    end else if (line_clk_i && phase_o == PH_SCAN) begin
      row_cnt_o <= row_cnt_o + 1'b1;  // wraps modulo 2**LINE_W
      com_o     <= com_o + 1'b1;
      if (com_o == LAST_SCAN) phase_o <= PH_ICON;
    end
  end
endmodule

// File: rtl/dsa_addr_sel.sv
module dsa_addr_sel
  import disp_scan_pkg::*;
#(
  parameter int LINE_W = 6,
  localparam int ADDR_W = LINE_W + 1
) (
  input  logic [LINE_W-1:0] row_cnt_i,
  input  scan_phase_e       phase_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] ICON_ROW = ADDR_W'(1 << LINE_W);

  always_comb begin
    if (phase_i == PH_ICON) addr_o = ICON_ROW;
    else                    addr_o = {1'b0, row_cnt_i};
  end
endmodule

// File: rtl/disp_row_addr_gen.sv
module disp_row_addr_gen
  import disp_scan_pkg::*;
#(
  parameter int LINE_W = 6,
  localparam int ADDR_W = LINE_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_wr_i,
  input  logic [LINE_W-1:0] start_val_i,
  input  logic              frame_start_i,
  input  logic              line_clk_i,
  output logic [ADDR_W-1:0] row_addr_o,
  output logic [ADDR_W-1:0] com_idx_o
);
  logic [LINE_W-1:0] start_q;
  logic [LINE_W-1:0] row_cnt;
  scan_phase_e       phase;

  dsa_start_reg #(.LINE_W(LINE_W)) u_start (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (start_wr_i),
    .val_i   (start_val_i),
    .start_o (start_q)
  );

  dsa_line_seq #(.LINE_W(LINE_W)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (frame_start_i),
    .line_clk_i    (line_clk_i),
    .start_i       (start_q),
    .row_cnt_o     (row_cnt),
    .com_o         (com_idx_o),
    .phase_o       (phase)
  );

  dsa_addr_sel #(.LINE_W(LINE_W)) u_sel (
    .row_cnt_i (row_cnt),
    .phase_i   (phase),
    .addr_o    (row_addr_o)
  );
endmodule

// File: rtl/dsa_checker.sv
module dsa_checker #(
  parameter int LINE_W = 6,
  localparam int ADDR_W = LINE_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_wr_i,
  input logic [LINE_W-1:0] start_val_i,
  input logic              frame_start_i,
  input logic              line_clk_i,
  input logic [ADDR_W-1:0] row_addr_o,
  input logic [ADDR_W-1:0] com_idx_o,
  input logic [LINE_W-1:0] start_q
);
  localparam logic [ADDR_W-1:0] ICON = ADDR_W'(1 << LINE_W);

  a_r2_start_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_wr_i |=> $stable(start_q));

  a_r2_start_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_wr_i |=> start_q == $past(start_val_i));

  a_r3_frame_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> (com_idx_o == '0) && (row_addr_o == {1'b0, $past(start_q)}));

  a_r4_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_clk_i && !frame_start_i && com_idx_o < ICON - 1'b1) |=>
      (com_idx_o == $past(com_idx_o) + 1'b1) &&
      (row_addr_o[LINE_W-1:0] == LINE_W'($past(row_addr_o[LINE_W-1:0]) + 1'b1)));

  a_r5_icon_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    com_idx_o == ICON |-> row_addr_o == ICON);

  a_r6_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (com_idx_o == ICON && !frame_start_i) |=> com_idx_o == ICON);

  a_r6_com_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    com_idx_o <= ICON);

  a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_start_i && !line_clk_i) |=> $stable(row_addr_o) && $stable(com_idx_o));
endmodule

bind disp_row_addr_gen dsa_checker #(.LINE_W(LINE_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_wr_i    (start_wr_i),
  .start_val_i   (start_val_i),
  .frame_start_i (frame_start_i),
  .line_clk_i    (line_clk_i),
  .row_addr_o    (row_addr_o),
  .com_idx_o     (com_idx_o),
  .start_q       (start_q)
);

// File: tb/disp_row_addr_gen_tb.sv
module disp_row_addr_gen_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_wr_i = 1'b0;
  logic [5:0] start_val_i = '0;
  logic       frame_start_i = 1'b0;
  logic       line_clk_i = 1'b0;
  logic [6:0] row_addr_o;
  logic [6:0] com_idx_o;

  int checks = 0;
  int errors = 0;

  always #4ns clk_i = ~clk_i;  // 125 MHz

  disp_row_addr_gen u_dut (
    .clk_i, .rst_ni, .start_wr_i, .start_val_i,
    .frame_start_i, .line_clk_i, .row_addr_o, .com_idx_o
  );

  typedef struct packed {
    logic [5:0] start;
    logic [7:0] pulses;
    logic [6:0] exp_row;
    logic [6:0] exp_com;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{6'd0,  8'd0,  7'd0,  7'd0},
    '{6'd5,  8'd10, 7'd15, 7'd10},
    '{6'd63, 8'd1,  7'd0,  7'd1},
    '{6'd40, 8'd30, 7'd6,  7'd30},
    '{6'd1,  8'd63, 7'd0,  7'd63},
    '{6'd17, 8'd64, 7'd64, 7'd64},
    '{6'd33, 8'd70, 7'd64, 7'd64},
    '{6'd62, 8'd2,  7'd0,  7'd2}
  };

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive at falling edge, pass one rising edge, return at next falling edge
  task automatic cyc(bit fs, bit lc, bit wr, logic [5:0] v);
    frame_start_i = fs;
    line_clk_i    = lc;
    start_wr_i    = wr;
    start_val_i   = v;
    @(posedge clk_i);
    @(negedge clk_i);
    frame_start_i = 1'b0;
    line_clk_i    = 1'b0;
    start_wr_i    = 1'b0;
  endtask

  function automatic int model_row(int s, int k);
    return (k >= 64) ? 64 : (s + k) % 64;
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    cyc(0, 1, 1, 6'd9);
    chk("R1 row in reset", int'(row_addr_o), 0);
    chk("R1 com in reset", int'(com_idx_o), 0);
    rst_ni = 1'b1;
    cyc(0, 0, 0, '0);
    chk("R1 row after reset", int'(row_addr_o), 0);
    cyc(1, 0, 0, '0);
    chk("R1 start reg reset value", int'(row_addr_o), 0);

    // vector table: R4 R5 R6
    foreach (VECS[i]) begin
      cyc(0, 0, 1, VECS[i].start);
      cyc(1, 0, 0, '0);
      for (int p = 0; p < int'(VECS[i].pulses); p++) cyc(0, 1, 0, '0);
      chk("R4/R5/R6 table row", int'(row_addr_o), int'(VECS[i].exp_row));
      chk("R4/R5/R6 table com", int'(com_idx_o), int'(VECS[i].exp_com));
    end

    // full sweep of start values against the modulo model (R4, R5, R6)
    for (int s = 0; s < 64; s++) begin
      cyc(0, 0, 1, 6'(s));
      cyc(1, 0, 0, '0);
      for (int k = 0; k <= 65; k++) begin
        chk("R4 sweep row", int'(row_addr_o), model_row(s, k));
        chk("R5 sweep com", int'(com_idx_o), (k > 64) ? 64 : k);
        cyc(0, 1, 0, '0);
      end
      chk("R6 saturated row", int'(row_addr_o), 64);
    end

    // R2: mid-frame write leaves current frame alone
    cyc(0, 0, 1, 6'd10);
    cyc(1, 0, 0, '0);
    repeat (5) cyc(0, 1, 0, '0);
    cyc(0, 0, 1, 6'd50);
    chk("R2 row after mid-frame write", int'(row_addr_o), 15);
    cyc(0, 1, 0, '0);
    chk("R2 frame continues old scroll", int'(row_addr_o), 16);
    cyc(1, 0, 0, '0);
    chk("R2 write visible at next frame", int'(row_addr_o), 50);
    cyc(1, 0, 0, '0);
    chk("R2 no write keeps start", int'(row_addr_o), 50);

    // R3: write together with frame start applies only next frame
    cyc(1, 0, 1, 6'd20);
    chk("R3 same-cycle write deferred", int'(row_addr_o), 50);
    cyc(1, 0, 0, '0);
    chk("R3 deferred write taken", int'(row_addr_o), 20);

    // R3: frame restart mid-frame
    repeat (7) cyc(0, 1, 0, '0);
    cyc(1, 0, 0, '0);
    chk("R3 restart row", int'(row_addr_o), 20);
    chk("R3 restart com", int'(com_idx_o), 0);

    // R7: frame start beats line pulse
    repeat (3) cyc(0, 1, 0, '0);
    cyc(1, 1, 0, '0);
    chk("R7 priority row", int'(row_addr_o), 20);
    chk("R7 priority com", int'(com_idx_o), 0);

    // R8: idle cycles hold outputs
    repeat (4) cyc(0, 1, 0, '0);
    repeat (6) cyc(0, 0, 0, '0);
    chk("R8 hold row", int'(row_addr_o), 24);
    chk("R8 hold com", int'(com_idx_o), 4);

    // R5: icon line ignores start line value
    cyc(0, 0, 1, 6'd63);
    cyc(1, 0, 0, '0);
    repeat (64) cyc(0, 1, 0, '0);
    chk("R5 icon row start 63", int'(row_addr_o), 64);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule